// File: doc/BRIEF.md
# Adaptive Green Time Decision Unit

This unit decides, one clock at a time, whether the phase now shown at a two-arm intersection should end. It reads the queued-car counts of both arms, a phase timer kept outside the block, the kind of phase now running and which arm that phase serves. It compares these against programmed minimum and maximum times. During a green phase it also uses the sign of a weighted imbalance between the two queues. When the phase should end, it sends the lamp sequencer a one-cycle switch request, together with a matching pulse that clears the phase timer.

The imbalance for the served arm is `weight * own_queue + bias - other_queue`. The weight is unsigned. The bias is a signed coefficient, so a learning stage elsewhere can push it either way. Only the sign of the result is used. A left-turn phase can also end early when its queue has stopped moving. A pedestrian phase simply runs for its programmed time.

Top module: `green_time_decider`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `sw_req` and `t_clr` are 0.
- R2: With `phase` = 0 (green) and `t` below the served arm's minimum, no request is raised. `arm_sel` = 0 serves arm A and `arm_sel` = 1 serves arm B.
- R3: In green, with `t` at or above the served arm's minimum and at or above its maximum, a request is raised whatever the queues are.
- R4: In green, with `t` at or above the minimum and below the maximum, a request is raised when the served arm's queue is 0.
- R5: In green, between the minimum and the maximum, a request is raised exactly when `weight*own + bias - other <= 0`. The bias is 11-bit two's complement and the weight is unsigned.
- R6: The imbalance is computed exactly across the full input ranges. For example, weight 2047, own queue 2047, bias -1024 and other queue 2047 is positive.
- R7: With `phase` = 1 (left turn), no request is raised while `t` is below `left_min`. A request is forced once `t` is at or above `left_min` and at or above `left_max`.
- R8: In left turn, between `left_min` and `left_max`, a request is raised once the served arm's queue has stayed the same over 5 changes of `t`. The count restarts at 0 when that queue changes or when the phase is not a left turn. The queue is compared with its value on the previous clock.
- R9: With `phase` = 2 (pedestrian), a request is raised once `t` is at or above `ped_time`, and never before.
- R10: With `phase` = 3 (yellow), no request is raised.
- R11: `sw_req` rises on the clock after its condition is present. It lasts one cycle and is not raised again until a yellow phase has been seen. `t_clr` pulses in the same cycle as `sw_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 2 | 0 green, 1 left turn, 2 pedestrian, 3 yellow |
| arm_sel | input | 1 | Arm served by the phase: 0 arm A, 1 arm B |
| t | input | 8 | Phase timer |
| q_a | input | 11 | Queued cars, arm A |
| q_b | input | 11 | Queued cars, arm B |
| min_a | input | 8 | Green minimum, arm A |
| max_a | input | 8 | Green maximum, arm A |
| min_b | input | 8 | Green minimum, arm B |
| max_b | input | 8 | Green maximum, arm B |
| left_min | input | 8 | Left-turn minimum |
| left_max | input | 8 | Left-turn maximum |
| ped_time | input | 8 | Pedestrian phase time |
| w_a | input | 11 | Weight, arm A (unsigned) |
| w_b | input | 11 | Weight, arm B (unsigned) |
| bias_a | input | 11 | Bias, arm A (signed) |
| bias_b | input | 11 | Bias, arm B (signed) |
| sw_req | output | 1 | One-cycle phase-end request |
| t_clr | output | 1 | One-cycle timer clear |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that any phase other than yellow is left by way of yellow, so that a request can be raised again. The bench drives every input on the falling edge and puts a yellow interval before each scenario. Timer sweeps start below each minimum and cross the maxima. Queue values and coefficients are chosen so that the imbalance is negative, zero, positive and at the extremes of its range.

// File: rtl/green_time_decider.sv
module green_time_decider #(
  parameter int CW          = 11,
  parameter int TW          = 8,
  parameter int STALL_TICKS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    phase,
  input  logic          arm_sel,
  input  logic [TW-1:0] t,
  input  logic [CW-1:0] q_a,
  input  logic [CW-1:0] q_b,
  input  logic [TW-1:0] min_a,
  input  logic [TW-1:0] max_a,
  input  logic [TW-1:0] min_b,
  input  logic [TW-1:0] max_b,
  input  logic [TW-1:0] left_min,
  input  logic [TW-1:0] left_max,
  input  logic [TW-1:0] ped_time,
  input  logic [CW-1:0] w_a,
  input  logic [CW-1:0] w_b,
  input  logic [CW-1:0] bias_a,
  input  logic [CW-1:0] bias_b,
  output logic          sw_req,
  output logic          t_clr
);
  localparam int FW  = 2*CW + 3;
  localparam int STW = $clog2(STALL_TICKS + 1);
  localparam logic [1:0] PH_GREEN = 2'd0;
  localparam logic [1:0] PH_LEFT  = 2'd1;
  localparam logic [1:0] PH_PED   = 2'd2;
  localparam logic [1:0] PH_YEL   = 2'd3;

  logic [CW-1:0]   own_n, oth_n, own_w, own_b;
  logic [TW-1:0]   own_min, own_max;
  logic [2*CW-1:0] prod;
  logic signed [FW-1:0] imbal;
  logic [TW-1:0]   t_prev;
  logic [CW-1:0]   n_prev;
  logic [STW-1:0]  stall_q;
  logic            held_q, want;
  logic            green_go, left_go, ped_go;

  assign own_n   = arm_sel ? q_b    : q_a;
  assign oth_n   = arm_sel ? q_a    : q_b;
  assign own_w   = arm_sel ? w_b    : w_a;
  assign own_b   = arm_sel ? bias_b : bias_a;
  assign own_min = arm_sel ? min_b  : min_a;
  assign own_max = arm_sel ? max_b  : max_a;

  assign prod  = {{CW{1'b0}}, own_w} * {{CW{1'b0}}, own_n};
  assign imbal = $signed({3'b000, prod})
               + $signed({{(FW-CW){own_b[CW-1]}}, own_b})
               - $signed({{(FW-CW){1'b0}}, oth_n});

  assign green_go = (t >= own_min) &&
                    ((t >= own_max) || (own_n == '0) || (imbal <= 0));
  assign left_go  = (t >= left_min) &&
                    ((t >= left_max) || (stall_q >= STW'(STALL_TICKS)));
  assign ped_go   = (t >= ped_time);

  always_comb begin
    case (phase)
      PH_GREEN: want = green_go;
      PH_LEFT:  want = left_go;
      PH_PED:   want = ped_go;
      default:  want = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_prev  <= '0;
      n_prev  <= '0;
      stall_q <= '0;
    end else begin
      t_prev <= t;
      n_prev <= own_n;
      if (phase != PH_LEFT || own_n != n_prev)
        stall_q <= '0;
      else if (t != t_prev && stall_q < STW'(STALL_TICKS))
        stall_q <= stall_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      sw_req <= 1'b0;
      t_clr  <= 1'b0;
    end else begin
      sw_req <= want && !held_q && phase != PH_YEL;
      t_clr  <= want && !held_q && phase != PH_YEL;
      held_q <= (phase == PH_YEL) ? 1'b0 : (held_q | want);
    end
  end
endmodule

module green_time_decider_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase,
  input logic          arm_sel,
  input logic [TW-1:0] t,
  input logic [TW-1:0] min_a,
  input logic [TW-1:0] min_b,
  input logic [TW-1:0] left_min,
  input logic [TW-1:0] ped_time,
  input logic          sw_req,
  input logic          t_clr
);
  a_r10_yellow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3) |=> !sw_req);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> !sw_req);
  a_r11_clr_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> t_clr);
  a_r2_green_min_a: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && !arm_sel && t < min_a) |=> !sw_req);
  a_r2_green_min_b: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && arm_sel && t < min_b) |=> !sw_req);
  a_r7_left_min: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && t < left_min) |=> !sw_req);
  a_r9_ped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && t < ped_time) |=> !sw_req);
endmodule

bind green_time_decider green_time_decider_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .arm_sel(arm_sel), .t(t),
  .min_a(min_a), .min_b(min_b), .left_min(left_min), .ped_time(ped_time),
  .sw_req(sw_req), .t_clr(t_clr)
);

// File: tb/green_time_decider_tb.sv
module green_time_decider_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0]  phase = 2'd3;
  logic        arm_sel = 0;
  logic [7:0]  t = 0, min_a = 0, max_a = 0, min_b = 0, max_b = 0;
  logic [7:0]  left_min = 0, left_max = 0, ped_time = 0;
  logic [10:0] q_a = 0, q_b = 0, w_a = 0, w_b = 0, bias_a = 0, bias_b = 0;
  logic sw_req, t_clr;

  int checks = 0, errors = 0, pulses = 0;
  string tag = "R1";
  bit done = 0;

  int m_tprev, m_nprev, m_stall;
  bit m_held, exp_req;

  always #5 clk = ~clk;

  green_time_decider u_dut (
    .clk(clk), .rst_n(rst_n), .phase(phase), .arm_sel(arm_sel), .t(t),
    .q_a(q_a), .q_b(q_b), .min_a(min_a), .max_a(max_a), .min_b(min_b),
    .max_b(max_b), .left_min(left_min), .left_max(left_max),
    .ped_time(ped_time), .w_a(w_a), .w_b(w_b), .bias_a(bias_a),
    .bias_b(bias_b), .sw_req(sw_req), .t_clr(t_clr)
  );

  always @(posedge clk) begin
    int own, oth, f, tv, mn, mx;
    bit want;
    if (!rst_n) begin
      m_tprev = 0; m_nprev = 0; m_stall = 0; m_held = 0; exp_req = 0;
    end else begin
      own = arm_sel ? int'(q_b) : int'(q_a);
      oth = arm_sel ? int'(q_a) : int'(q_b);
      f   = (arm_sel ? int'(w_b) : int'(w_a)) * own
          + (arm_sel ? int'($signed(bias_b)) : int'($signed(bias_a))) - oth;
      mn  = arm_sel ? int'(min_b) : int'(min_a);
      mx  = arm_sel ? int'(max_b) : int'(max_a);
      tv  = int'(t);
      case (phase)
        2'd0: want = (tv >= mn) && (tv >= mx || own == 0 || f <= 0);
        2'd1: want = (tv >= int'(left_min)) &&
                     (tv >= int'(left_max) || m_stall >= 5);
        2'd2: want = tv >= int'(ped_time);
        default: want = 0;
      endcase
      if (phase != 2'd1 || own != m_nprev) m_stall = 0;
      else if (tv != m_tprev && m_stall < 5) m_stall++;
      m_tprev = tv; m_nprev = own;
      exp_req = want && !m_held && phase != 2'd3;
      m_held  = (phase == 2'd3) ? 0 : (m_held | want);
    end
  end

  task automatic step();
    @(negedge clk);
    checks++;
    if (sw_req !== exp_req || t_clr !== exp_req) begin
      errors++;
      $display("FAIL %s: sw_req=%b t_clr=%b expected %b", tag, sw_req, t_clr, exp_req);
    end
    if (sw_req === 1'b1) pulses++;
  endtask

  task automatic yellow();
    phase = 2'd3; t = 0;
    repeat (2) step();
  endtask

  task automatic sweep(input logic [1:0] ph, input logic arm, input int t0,
                       input int n, input int exp_pulses, input string rt);
    yellow();
    tag = rt; phase = ph; arm_sel = arm; pulses = 0;
    for (int i = 0; i < n; i++) begin
      t = 8'(t0 + i);
      step();
    end
    checks++;
    if (pulses != exp_pulses) begin
      errors++;
      $display("FAIL %s: pulses=%0d expected %0d", rt, pulses, exp_pulses);
    end
  endtask

  initial begin
    tag = "R1";
    repeat (3) step();
    @(negedge clk); rst_n = 1;
    step();

    min_a = 10; max_a = 20; min_b = 6; max_b = 30;
    w_a = 1; bias_a = 11'd100; q_a = 5; q_b = 3;
    sweep(2'd0, 0, 0, 26, 1, "R3");
    sweep(2'd0, 0, 0, 9, 0, "R2");

    q_b = 0; w_b = 3; bias_b = 11'd50; q_a = 40;
    sweep(2'd0, 1, 0, 12, 1, "R4");

    q_a = 3; q_b = 0; bias_a = 11'h7FB;
    sweep(2'd0, 0, 0, 15, 1, "R5");
    max_a = 200; w_a = 2; bias_a = 0; q_a = 3; q_b = 5;
    sweep(2'd0, 0, 0, 60, 0, "R5");
    w_a = 1; bias_a = 11'd1; q_a = 4; q_b = 5;
    sweep(2'd0, 0, 0, 20, 1, "R5");

    max_a = 255; w_a = 11'd2047; q_a = 11'd2047; bias_a = 11'h400; q_b = 11'd2047;
    sweep(2'd0, 0, 0, 120, 0, "R6");
    w_a = 0;
    sweep(2'd0, 0, 0, 15, 1, "R6");

    left_min = 5; left_max = 40; q_a = 7;
    sweep(2'd1, 0, 0, 3, 0, "R7");
    sweep(2'd1, 0, 30, 15, 1, "R7");

    yellow();
    tag = "R8"; phase = 2'd1; arm_sel = 0; pulses = 0;
    for (int i = 0; i < 36; i++) begin
      t = 8'(i);
      if (i < 20 && i % 2 == 0) q_a = q_a + 1;
      step();
    end
    checks++;
    if (pulses != 1) begin
      errors++;
      $display("FAIL R8: stall pulses=%0d expected 1", pulses);
    end
    yellow();
    tag = "R8"; phase = 2'd1; pulses = 0; t = 10;
    repeat (20) step();
    checks++;
    if (pulses != 0) begin
      errors++;
      $display("FAIL R8: frozen-timer pulses=%0d expected 0", pulses);
    end

    ped_time = 12;
    sweep(2'd2, 1, 0, 20, 1, "R9");

    yellow();
    tag = "R10"; pulses = 0; t = 8'd250;
    repeat (10) step();
    checks++;
    if (pulses != 0) begin
      errors++;
      $display("FAIL R10: pulses=%0d expected 0", pulses);
    end

    min_a = 2; max_a = 100; w_a = 0; bias_a = 0; q_a = 9; q_b = 4;
    yellow();
    tag = "R11"; phase = 2'd0; arm_sel = 0; pulses = 0; t = 5;
    repeat (12) step();
    checks++;
    if (pulses != 1) begin
      errors++;
      $display("FAIL R11: pulses=%0d expected 1", pulses);
    end
    sweep(2'd0, 0, 5, 4, 1, "R11");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule